// File: doc/BRIEF.md
# DSSS BPSK Chip Spreader

This block turns a slow data stream into a binary-phase-shift, direct-sequence spread-spectrum waveform. The waveform is a single serial bit driven at the system clock rate. It holds a fixed pseudo-random spreading code of 1024 chips, kept as 32 words of 32 bits. The block steps through the code one chip at a time. Each chip is XORed with the data bit in force. The result picks one of two opposite-phase alternating 32-bit carrier words, and that word is shifted out one bit per clock.

The carrier therefore runs at half the clock rate. A chip lasts 32 clocks, and one data bit covers the whole 32768-clock code period, so all timing is locked to the clock by powers of two. Software starts transmission with a `start` pulse while `enable` is high. The block asks for each data bit with a one-cycle `data_ready` pulse. If no bit is offered in that cycle, it keeps sending the previous one.

Top module: `dsss_spreader`

## Requirements
- R1: After reset, `carrier_out` and `data_ready` are 0 until a start is accepted.
- R2: A start is accepted when `start` and `enable` are high while the block is idle. In that cycle `data_ready` is 1. If `data_valid` is also 1, then `data_in` becomes the data bit of the first period. Otherwise the previously held bit is used, which is 0 after reset.
- R3: Code word w (0 to 31) is {m, ~m}, where m is the low 16 bits of w*40503 + 12345. Every word, and so the whole code, therefore holds as many ones as zeros. Chips are used from word 0 up to word 31, most significant bit first within each word.
- R4: Each chip lasts 32 clocks. If chip XOR data bit is 1, the 32 carrier bits are 0,1,0,1,... (the word 0xAAAAAAAA sent least significant bit first). If it is 0, they are 1,0,1,0,... (0x55555555). Inside a chip the output toggles every clock.
- R5: `carrier_out` in the cycle after the k-th rising edge that follows the start edge carries tick k of the period. Tick k uses chip k/32 and pattern bit k mod 32, with no gap between words.
- R6: A period is 32768 clocks and then repeats from word 0 without a pause. `data_ready` is a one-cycle pulse in the last clock of each period (tick 32767), and is 0 at every other tick.
- R7: If `data_valid` is 0 during the `data_ready` pulse, the next period reuses the previous data bit. If it is 1, `data_in` applies to the whole next period.
- R8: While `enable` is 0, `carrier_out` and `data_ready` are 0 in the same cycle and the position counters return to zero. After `enable` returns, the output stays 0 until a new start, which begins again at tick 0.
- R9: A `start` pulse while running has no effect on the output sequence.
- R10: `data_valid` and `data_in` outside a `data_ready` cycle have no effect on the output sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one carrier bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low forces idle and zero output |
| start | input | 1 | Begins transmission when idle |
| data_in | input | 1 | Data bit offered for the next code period |
| data_valid | input | 1 | Qualifies `data_in` during `data_ready` |
| data_ready | output | 1 | One-cycle request for the next data bit |
| carrier_out | output | 1 | Serial BPSK carrier bit |

## Verification
The carrier is compared tick by tick over two complete code periods. The first period uses data bit 1, and the second reuses it because no new bit is offered. That pairing separates XOR inversion of the code from a stuck or inverted pattern choice, and it checks the hold rule. A third period with data 0 confirms the non-inverted mapping. Starts and valid data offered mid-period test the ignore rules. An enable drop followed by a fresh start shows that the counters restart at tick 0 rather than resuming.

// File: rtl/dsss_spreader.sv
module dsss_spreader #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 32,
  parameter int MULT    = 40503,
  parameter int ADD     = 12345
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic start,
  input  logic data_in,
  input  logic data_valid,
  output logic data_ready,
  output logic carrier_out
);

  localparam int HALF   = WORD_W / 2;
  localparam int BW     = $clog2(WORD_W);
  localparam int WIDX_W = $clog2(N_WORDS);
  localparam int POS_W  = WIDX_W + 2 * BW;

  function automatic logic [WORD_W-1:0] code_word(input logic [WIDX_W-1:0] w);
    logic [HALF-1:0] m;
    m = HALF'(int'(w) * MULT + ADD);
    return {m, ~m};
  endfunction

  function automatic logic [WORD_W-1:0] pattern(input logic sel);
    return sel ? {HALF{2'b10}} : {HALF{2'b01}};
  endfunction

  logic              running;
  logic              dbit;
  logic [POS_W-1:0]  pos;
  logic [WORD_W-1:0] cword;
  logic [WORD_W-1:0] shreg;

  wire last_bit   = pos[BW-1:0] == '1;
  wire last_chip  = pos[2*BW-1:BW] == '1;
  wire period_end = pos == '1;
  wire accept     = enable && !running && start;

  wire [WIDX_W-1:0] widx_nx = pos[POS_W-1:2*BW] + 1'b1;
  wire [WORD_W-1:0] word_nx = code_word(widx_nx);
  wire [WORD_W-1:0] word_0  = code_word('0);

  wire              chip_nx  = last_chip ? word_nx[WORD_W-1] : cword[WORD_W-1];
  wire [WORD_W-1:0] cword_nx = last_chip ? {word_nx[WORD_W-2:0], 1'b0}
                                         : {cword[WORD_W-2:0], 1'b0};
  wire              take     = (accept || (running && period_end)) && data_valid;
  wire              dbit_nx  = take ? data_in : dbit;

  assign data_ready  = enable && (accept || (running && period_end));
  assign carrier_out = enable && running && shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      dbit    <= 1'b0;
      pos     <= '0;
      cword   <= '0;
      shreg   <= '0;
    end else if (!enable) begin
      running <= 1'b0;
      pos     <= '0;
      shreg   <= '0;
    end else if (accept) begin
      running <= 1'b1;
      dbit    <= dbit_nx;
      pos     <= '0;
      cword   <= {word_0[WORD_W-2:0], 1'b0};
      shreg   <= pattern(word_0[WORD_W-1] ^ dbit_nx);
    end else if (running) begin
      pos  <= pos + 1'b1;
      dbit <= dbit_nx;
      if (last_bit) begin
        cword <= cword_nx;
        shreg <= pattern(chip_nx ^ dbit_nx);
      end else begin
        shreg <= {1'b0, shreg[WORD_W-1:1]};
      end
    end
  end

  // R4: carrier toggles every clock inside a chip
  p_toggle_in_chip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && enable && !last_bit) ##1 enable |-> carrier_out != $past(carrier_out));

  // R6: ready is a single-cycle pulse while running
  p_ready_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && running) |=> !data_ready);

  // R8: enable low returns the block to idle at tick zero
  p_disable_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!running && pos == '0));

  // R9: a running block stays running while enabled
  p_keep_running_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && enable) |=> (running || !enable));

endmodule

// File: tb/dsss_spreader_test.sv
module dsss_spreader_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic start = 1'b0;
  logic data_in = 1'b0;
  logic data_valid = 1'b0;
  logic data_ready;
  logic carrier_out;

  always #4 clk = ~clk;

  dsss_spreader uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
    .data_in(data_in), .data_valid(data_valid),
    .data_ready(data_ready), .carrier_out(carrier_out)
  );

  typedef struct {
    logic  c;
    logic  r;
    int    k;
    string tag;
  } item_t;

  item_t q[$];
  item_t mon_it;
  int n_checks = 0;
  int n_fail = 0;

  function automatic logic exp_carrier(int k, logic d);
    logic [15:0] m;
    logic [31:0] w;
    logic chip;
    m = 16'((k >> 10) * 40503 + 12345);
    w = {m, ~m};
    chip = w[31 - ((k >> 5) & 31)];
    return (chip ^ d) ? k[0] : ~k[0];
  endfunction

  task automatic check(input string tag, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %b expected %b", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      mon_it = q.pop_front();
      n_checks++;
      if (carrier_out !== mon_it.c) begin
        n_fail++;
        $display("FAIL %s carrier tick %0d got %b expected %b", mon_it.tag, mon_it.k, carrier_out, mon_it.c);
      end
      n_checks++;
      if (data_ready !== mon_it.r) begin
        n_fail++;
        $display("FAIL R6 ready tick %0d got %b expected %b", mon_it.k, data_ready, mon_it.r);
      end
    end
  end

  task automatic run(input int n, input logic d, input logic nv, input logic nd,
                     input logic noise, input string tag);
    for (int k = 0; k < n; k++) begin
      item_t it;
      @(posedge clk); #1;
      start = 1'b0;
      data_valid = 1'b0;
      it.c = exp_carrier(k, d);
      it.r = (k == 32767);
      it.k = k;
      it.tag = tag;
      q.push_back(it);
      if (k == 32767) begin
        data_valid = nv;
        data_in = nd;
      end else if (noise && (k % 997) == 3) begin
        data_valid = 1'b1;
        data_in = ~d;
        start = 1'b1;
      end
    end
  endtask

  task automatic do_start(input logic v, input logic d);
    @(posedge clk); #1;
    start = 1'b1;
    data_valid = v;
    data_in = d;
    #1;
    check("R2 ready in start cycle", data_ready, 1'b1);
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 carrier after reset", carrier_out, 1'b0);
    check("R1 ready after reset", data_ready, 1'b0);
    rst_n = 1'b1;
    enable = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 idle carrier", carrier_out, 1'b0);

    // R2 R3 R4 R5 R9 R10: first period with data 1, mid-period noise
    do_start(1'b1, 1'b1);
    run(32768, 1'b1, 1'b0, 1'b0, 1'b1, "R3 R4 R5 R9 R10");
    // R7: no bit offered, data 1 held; then offer 0 for the next period
    run(32768, 1'b1, 1'b1, 1'b0, 1'b0, "R7 R6");
    run(2000, 1'b0, 1'b0, 1'b0, 1'b0, "R7 new bit");

    // R8: enable drop
    @(posedge clk); #1;
    enable = 1'b0;
    #1;
    check("R8 carrier low with enable low", carrier_out, 1'b0);
    check("R8 ready low with enable low", data_ready, 1'b0);
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #2;
      check("R8 disabled output", carrier_out, 1'b0);
    end
    enable = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #2;
      check("R8 no resume without start", carrier_out, 1'b0);
      check("R8 no ready without start", data_ready, 1'b0);
    end
    do_start(1'b1, 1'b0);
    run(5000, 1'b0, 1'b0, 1'b0, 1'b0, "R8 restart at tick 0");
    @(posedge clk); #1;
    repeat (2) @(posedge clk);
    finish_up();
  end

endmodule